// File: doc/BRIEF.md
# Soft-Start Gate Pulse Generator

This block drives the gate-command line of a switching power stage with a fixed-frequency pulse train. The same line serves as the enable of the downstream driver: while it is low the stage is off. The block therefore keeps the line low until an enable input and a power-good input are both high, and it drops the line at once when either of them falls or when a forced stop is requested.

Once qualified, the block starts a switching period at every rising edge of the output. The period length is set in clock ticks by a register. The on-time of the first period is one ramp step. Each later period adds one more step, and the on-time stops growing at a programmed ceiling that bounds the volt-seconds applied to the transformer. The frequency never changes during the ramp. A status bit reports that the ramp has reached the ceiling. The period and ceiling registers are sampled only at period boundaries, so software may rewrite them at any time.

Top module: `soft_pwm_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, gate_o and ss_done_o are low, whatever the other inputs are.
- R2: gate_o is low in every cycle in which en_i or pwr_good_i is low, including the same cycle in which either falls. A start happens only at a clock edge where en_i=1, pwr_good_i=1 and stop_i=0.
- R3: While running, successive periods last exactly P clock cycles, where P is period_i as sampled for that period. Any value below 2 is treated as 2.
- R4: Within a period, gate_o is high during the first D cycles and low for the rest, where D is that period's duty value.
- R5: In the first period after a start, D = min(step, T). In each later period, D = min(previous D + step, T), computed without wrap-around. Here step is ramp_step_i and T is the effective target.
- R6: The effective target T is min(duty_max_i, P-1), so every period ends with at least one low cycle.
- R7: ss_done_o is high in exactly those running cycles whose period has D equal to T.
- R8: stop_i=1 forces gate_o and ss_done_o low in the same cycle and returns the block to idle. The next start ramps again from its first step.
- R9: A change to period_i or duty_max_i in the middle of a period does not alter the current period. It takes effect from the next period boundary.
- R10: While running, D never exceeds T, and the tick counter stays below P.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick of duty and period resolution |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Run request from the controller |
| pwr_good_i | input | 1 | Reference/supply ready qualification |
| period_i | input | W | Switching period in ticks (values below 2 mean 2) |
| duty_max_i | input | W | Steady-state on-time ceiling in ticks |
| ramp_step_i | input | W | On-time increment per period during soft start |
| stop_i | input | 1 | Forced stop; ends the pulse immediately |
| gate_o | output | 1 | Gate command; doubles as driver enable |
| ss_done_o | output | 1 | High while the on-time equals the ceiling |

## Verification
On every cycle the assertions check the following. The tick counter stays inside the period. The on-time stays at or below a ceiling, and that ceiling stays below the period. The shadowed period and on-time hold still inside a period. Each rising output edge falls on tick zero. A forced stop always leaves the block idle. The exact pulse shape under a given register set can only be shown by the bench's sweeps over period, ceiling and step: the rising-edge spacing, the on-time of each ramp period and the cycle in which done rises. The same holds for the deferral of mid-period register writes and the restart from the first step after a stop.

// File: rtl/soft_pwm_pkg.sv
// Shared types for the soft-start gate pulse generator.
package soft_pwm_pkg;
    // Run state of the generator: idle holds the gate low, run issues pulses.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } spg_state_e;
endpackage

// File: rtl/spg_seq.sv
// Run/idle sequencer.
// Starts the generator when enable, power-good are high and stop is low;
// returns to idle as soon as that qualification is lost.
// Assumes: all inputs synchronous to clk.
module spg_seq
    import soft_pwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic pwr_good_i,
    input  logic stop_i,
    output logic start_o,
    output logic halt_o,
    output logic run_o
);
    spg_state_e state_q;
    logic       qual;

    // Qualification and transition strobes.
    always_comb begin
        qual    = en_i && pwr_good_i && !stop_i;
        start_o = (state_q == ST_IDLE) && qual;
        halt_o  = (state_q == ST_RUN) && !qual;
        run_o   = (state_q == ST_RUN);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (start_o) begin
            state_q <= ST_RUN;
        end else if (halt_o) begin
            state_q <= ST_IDLE;
        end
    end
endmodule

// File: rtl/spg_period.sv
// Period tick counter with shadowed period length.
// The period register is sampled at start and at each wrap only; values
// below 2 are raised to 2. Assumes W >= 2.
module spg_period #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         halt_i,
    input  logic         run_i,
    input  logic [W-1:0] period_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] per_o,
    output logic [W-1:0] per_nx_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] PER_MIN = W'(2);
    localparam logic [W-1:0] ONE     = W'(1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] per_q;

    // Sanitized next period and end-of-period strobe.
    always_comb begin
        per_nx_o = (period_i < PER_MIN) ? PER_MIN : period_i;
        wrap_o   = run_i && !halt_i && (cnt_q == per_q - ONE);
        cnt_o    = cnt_q;
        per_o    = per_q;
    end

    // Counter and period shadow update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            per_q <= PER_MIN;
        end else if (start_i) begin
            cnt_q <= '0;
            per_q <= per_nx_o;
        end else if (halt_i) begin
            cnt_q <= '0;
        end else if (wrap_o) begin
            cnt_q <= '0;
            per_q <= per_nx_o;
        end else if (run_i) begin
            cnt_q <= cnt_q + ONE;
        end
    end
endmodule

// File: rtl/spg_ramp.sv
// Soft-start duty ramp.
// Loads the first step at start, adds one step per period boundary and
// saturates at the target. The target is clamped to one below the period
// that begins at the same boundary.
// Assumes per_nx_i >= 2.
module spg_ramp #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         halt_i,
    input  logic         wrap_i,
    input  logic [W-1:0] per_nx_i,
    input  logic [W-1:0] duty_max_i,
    input  logic [W-1:0] step_i,
    output logic [W-1:0] duty_o,
    output logic [W-1:0] tgt_o
);
    localparam int EW = W + 1;

    logic [W-1:0]  duty_q;
    logic [W-1:0]  tgt_q;
    logic [W-1:0]  tgt_nx;
    logic [W-1:0]  base;
    logic [EW-1:0] sum;
    logic [W-1:0]  duty_nx;

    // Clamped target and saturating next duty.
    always_comb begin
        tgt_nx  = (duty_max_i < per_nx_i) ? duty_max_i : (per_nx_i - W'(1));
        base    = start_i ? '0 : duty_q;
        sum     = {1'b0, base} + {1'b0, step_i};
        duty_nx = (sum > {1'b0, tgt_nx}) ? tgt_nx : sum[W-1:0];
        duty_o  = duty_q;
        tgt_o   = tgt_q;
    end

    // Duty and target shadow registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q <= '0;
            tgt_q  <= '0;
        end else if (halt_i) begin
            duty_q <= '0;
        end else if (start_i || wrap_i) begin
            duty_q <= duty_nx;
            tgt_q  <= tgt_nx;
        end
    end
endmodule

// File: rtl/soft_pwm_gen.sv
// Soft-start gate pulse generator (top).
// Produces a fixed-period gate pulse whose on-time ramps one step per period
// up to a ceiling. The gate also acts as driver enable, so it is forced low
// combinationally whenever qualification is lost.
// Assumes W >= 2; all inputs synchronous to clk.
module soft_pwm_gen #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         pwr_good_i,
    input  logic [W-1:0] period_i,
    input  logic [W-1:0] duty_max_i,
    input  logic [W-1:0] ramp_step_i,
    input  logic         stop_i,
    output logic         gate_o,
    output logic         ss_done_o
);
    logic         start_w;
    logic         halt_w;
    logic         run_w;
    logic         wrap_w;
    logic [W-1:0] cnt_w;
    logic [W-1:0] per_w;
    logic [W-1:0] per_nx_w;
    logic [W-1:0] duty_w;
    logic [W-1:0] tgt_w;

    spg_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .pwr_good_i (pwr_good_i),
        .stop_i     (stop_i),
        .start_o    (start_w),
        .halt_o     (halt_w),
        .run_o      (run_w)
    );

    spg_period #(.W(W)) u_period (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_w),
        .halt_i   (halt_w),
        .run_i    (run_w),
        .period_i (period_i),
        .cnt_o    (cnt_w),
        .per_o    (per_w),
        .per_nx_o (per_nx_w),
        .wrap_o   (wrap_w)
    );

    spg_ramp #(.W(W)) u_ramp (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_w),
        .halt_i     (halt_w),
        .wrap_i     (wrap_w),
        .per_nx_i   (per_nx_w),
        .duty_max_i (duty_max_i),
        .step_i     (ramp_step_i),
        .duty_o     (duty_w),
        .tgt_o      (tgt_w)
    );

    // Gate compare and done status, both gated by live qualification.
    always_comb begin
        gate_o    = run_w && !halt_w && (cnt_w < duty_w);
        ss_done_o = run_w && !halt_w && (duty_w == tgt_w);
    end
endmodule

// File: rtl/spg_checker.sv
// Property checker for soft_pwm_gen, attached by bind.
module spg_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         stop_i,
    input logic         gate_o,
    input logic         run_q,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] per_q,
    input logic [W-1:0] duty_q,
    input logic [W-1:0] tgt_q
);
    // Tick counter stays inside the period (R3, R10).
    assert_cnt_in_period_R10: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q < per_q));

    // Duty never exceeds the ceiling (R10).
    assert_duty_le_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (duty_q <= tgt_q));

    // Ceiling leaves at least one low tick (R6).
    assert_target_below_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (tgt_q < per_q));

    // Period shadow holds inside a period (R9).
    assert_period_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q != '0) |-> $stable(per_q));

    // Duty changes only at a boundary (R5).
    assert_duty_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q != '0) |-> $stable(duty_q));

    // A rising gate edge marks tick zero (R4).
    assert_rise_at_tick0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> (cnt_q == '0));

    // Forced stop leaves the block idle (R8).
    assert_stop_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !run_q);
endmodule

bind soft_pwm_gen spg_checker #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .stop_i (stop_i),
    .gate_o (gate_o),
    .run_q  (run_w),
    .cnt_q  (cnt_w),
    .per_q  (per_w),
    .duty_q (duty_w),
    .tgt_q  (tgt_w)
);

// File: tb/soft_pwm_gen_tb.sv
// Sweep bench for soft_pwm_gen: expected pulse shapes computed arithmetically.
module soft_pwm_gen_tb;
    localparam int W = 8;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en_i = 1'b0;
    logic         pwr_good_i = 1'b0;
    logic [W-1:0] period_i = '0;
    logic [W-1:0] duty_max_i = '0;
    logic [W-1:0] ramp_step_i = '0;
    logic         stop_i = 1'b0;
    logic         gate_o;
    logic         ss_done_o;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    soft_pwm_gen #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .pwr_good_i(pwr_good_i),
        .period_i(period_i), .duty_max_i(duty_max_i), .ramp_step_i(ramp_step_i),
        .stop_i(stop_i), .gate_o(gate_o), .ss_done_o(ss_done_o)
    );

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_per(input int p);
        return (p < 2) ? 2 : p;
    endfunction

    function automatic int eff_tgt(input int t, input int p);
        return (t < eff_per(p)) ? t : eff_per(p) - 1;
    endfunction

    function automatic int duty_of(input int k, input int s, input int tg);
        int v = (k + 1) * s;
        return (v > tg) ? tg : v;
    endfunction

    // Start at the next edge and check nper periods cycle by cycle (R3-R7).
    task automatic run_cfg(input int p, input int t, input int s, input int nper);
        int pe = eff_per(p);
        int te = eff_tgt(t, p);
        @(negedge clk);
        period_i = W'(p); duty_max_i = W'(t); ramp_step_i = W'(s);
        en_i = 1'b1; pwr_good_i = 1'b1;
        for (int c = 0; c < pe * nper; c++) begin
            int k = c / pe;
            int ph = c % pe;
            int d = duty_of(k, s, te);
            @(negedge clk);
            check(int'(gate_o), int'(ph < d), $sformatf("R3 R4 R5 R6 gate p=%0d t=%0d s=%0d c=%0d", p, t, s, c));
            check(int'(ss_done_o), int'(d == te), $sformatf("R7 done p=%0d t=%0d s=%0d c=%0d", p, t, s, c));
        end
        en_i = 1'b0;
        #1;
        check(int'(gate_o), 0, "R2 gate low on enable drop");
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int pers[6] = '{0, 1, 2, 3, 6, 9};
        int tgts[4] = '{0, 1, 4, 20};
        int stps[4] = '{0, 1, 3, 200};

        // R1: reset state with qualification already present.
        en_i = 1'b1; pwr_good_i = 1'b1; period_i = 8'd5; duty_max_i = 8'd3; ramp_step_i = 8'd1;
        repeat (3) begin
            @(negedge clk);
            check(int'(gate_o), 0, "R1 gate in reset");
            check(int'(ss_done_o), 0, "R1 done in reset");
        end
        en_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(int'(gate_o), 0, "R1 gate after reset");
        check(int'(ss_done_o), 0, "R1 done after reset");

        // R2: enable without power-good issues nothing.
        en_i = 1'b1; pwr_good_i = 1'b0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            check(int'(gate_o), 0, "R2 no pulse without power good");
        end
        en_i = 1'b0;
        @(negedge clk);

        // Near-exhaustive sweep.
        foreach (pers[i]) foreach (tgts[j]) foreach (stps[k])
            run_cfg(pers[i], tgts[j], stps[k], 5);

        // Wide range: saturation without wrap-around (R5).
        run_cfg(255, 254, 200, 3);

        // R2: power-good drop mid-pulse forces gate low in the same cycle.
        @(negedge clk);
        period_i = 8'd8; duty_max_i = 8'd6; ramp_step_i = 8'd6;
        en_i = 1'b1; pwr_good_i = 1'b1;
        repeat (3) @(negedge clk);
        check(int'(gate_o), 1, "R2 pulse before power-good drop");
        pwr_good_i = 1'b0;
        #1;
        check(int'(gate_o), 0, "R2 gate low on power-good drop");
        en_i = 1'b0; pwr_good_i = 1'b1;
        @(negedge clk);

        // R8: stop mid-ramp, then restart from the first step.
        period_i = 8'd6; duty_max_i = 8'd5; ramp_step_i = 8'd2;
        en_i = 1'b1;
        repeat (7) @(negedge clk);
        check(int'(gate_o), 1, "R8 second-period pulse before stop");
        stop_i = 1'b1;
        #1;
        check(int'(gate_o), 0, "R8 gate low on stop");
        check(int'(ss_done_o), 0, "R8 done low on stop");
        @(negedge clk);
        check(int'(gate_o), 0, "R8 gate held low while stopped");
        stop_i = 1'b0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            check(int'(gate_o), int'((c % 6) < ((c < 6) ? 2 : 4)), $sformatf("R8 restart ramp c=%0d", c));
        end
        en_i = 1'b0;
        @(negedge clk);

        // R9: mid-period register writes wait for the boundary.
        period_i = 8'd8; duty_max_i = 8'd4; ramp_step_i = 8'd4;
        en_i = 1'b1;
        for (int c = 0; c < 18; c++) begin
            int exp;
            @(negedge clk);
            if (c == 3) begin
                period_i = 8'd5; duty_max_i = 8'd2;
            end
            exp = (c < 8) ? int'(c < 4) : int'(((c - 8) % 5) < 2);
            check(int'(gate_o), exp, $sformatf("R9 deferred update c=%0d", c));
        end
        en_i = 1'b0;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule